// File: doc/BRIEF.md
# Dual-Channel Exponential Sample Averager

This block smooths digitised samples taken in two gated windows of a repeating trigger cycle. One window carries the wanted response and the other carries the baseline. Each window has its own running average. A new sample moves its average a fraction 1/2^k of the way toward the sample. The shift setting k is shared by both channels and can be changed at any time. The fraction comes from an arithmetic right shift, so no divider is needed. A setting of zero replaces the stored value outright, which suits single-shot capture.

After every signal-channel update, the block registers the signal average minus the baseline average. This difference is saturated to the sample width, and a one-cycle strobe marks it as valid. Each accumulator carries fractional bits below the sample resolution, so long smoothing settings still track small changes. A clear input re-arms both channels so that each loads its next sample directly. One update takes two clock cycles, far inside a 10 µs budget per trigger cycle.

Top module: `exp_avg_top`

## Requirements
- R1: Reset (synchronous, active high) sets both averages, the difference and the valid strobe to zero.
- R2: After reset, the first valid sample on each channel is loaded directly into that channel's average.
- R3: With a shift setting k from 1 to 8, an update computes acc + ((sample·2^F − acc) >>> k). Here F = 8 fractional bits and >>> is an arithmetic shift (floor). The average output is floor(acc / 2^F).
- R4: A shift setting of 0 replaces the stored value with the new sample.
- R5: A shift setting above 8 acts as 8.
- R6: A sample on one channel leaves the other channel's average unchanged. A baseline-only sample produces no valid strobe.
- R7: The valid strobe is high exactly one cycle after the cycle in which a signal sample updates its average. It comes two clock edges after the sample is presented.
- R8: The difference is signal average minus baseline average. It saturates to the signed sample range (16 bits by default: +32767 and −32768) and does not wrap.
- R9: Asserting the clear input changes neither average. The next valid sample on each channel loads directly, and this includes a sample presented in the same cycle as the clear.
- R10: A change to the shift setting applies from the next sample on. It does not alter the stored averages.
- R11: Fractional residue is kept. Repeated small samples at k = 8 move the average even when a single step is below one sample unit.
- R12: When both channels take a sample in the same cycle, the difference uses the updated baseline average.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Re-arm both channels for a direct load |
| ksel | input | 4 | Shift setting k (values above 8 act as 8) |
| sig_vld | input | 1 | Signal-window sample valid |
| sig_smp | input | 16 | Signal-window sample, signed |
| zero_vld | input | 1 | Baseline-window sample valid |
| zero_smp | input | 16 | Baseline-window sample, signed |
| sig_avg | output | 16 | Signal average, integer part, signed |
| zero_avg | output | 16 | Baseline average, integer part, signed |
| res_diff | output | 16 | Saturated difference, signed |
| res_vld | output | 1 | One-cycle valid strobe for res_diff |

## Verification
Several input patterns exercise the averaging:
- A constant positive sequence at k = 3 tells the shift-blend law apart from plain replacement or plain accumulation.
- Alternating signs at k = 1 expose any rounding that is not floor.
- A long run of unit samples at k = 8 separates an accumulator that keeps its fraction from one that truncates.
- Extreme opposite samples at k = 0 show whether the difference saturates or wraps.
- Settings 12 and 8 are run on matched data to confirm the clamp.

Sequences with clear, with a setting change and with baseline-only samples show that stored state survives where it should.

// File: rtl/exp_avg_pkg.sv
package exp_avg_pkg;

    localparam int DEF_SAMPLE_W = 16;
    localparam int DEF_FRAC_W   = 8;
    localparam int DEF_KSEL_W   = 4;
    localparam int DEF_MAX_SHIFT = 8;

    localparam int CH_SIG  = 0;
    localparam int CH_ZERO = 1;
    localparam int N_CH    = 2;

    typedef enum logic [1:0] {
        UPD_HOLD  = 2'd0,
        UPD_LOAD  = 2'd1,
        UPD_BLEND = 2'd2
    } upd_kind_t;

    function automatic int shift_w(input int max_shift);
        return (max_shift < 1) ? 1 : $clog2(max_shift + 1);
    endfunction

endpackage

// File: rtl/exp_avg_chan.sv
module exp_avg_chan
    import exp_avg_pkg::*;
#(
    parameter int SAMPLE_W  = DEF_SAMPLE_W,
    parameter int FRAC_W    = DEF_FRAC_W,
    parameter int KSEL_W    = DEF_KSEL_W,
    parameter int MAX_SHIFT = DEF_MAX_SHIFT
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clr,
    input  logic [KSEL_W-1:0]          ksel,
    input  logic                       smp_vld,
    input  logic signed [SAMPLE_W-1:0] smp,
    output logic signed [SAMPLE_W-1:0] avg,
    output logic                       upd_q
);
    localparam int ACC_W = SAMPLE_W + FRAC_W;
    localparam int SH_W  = shift_w(MAX_SHIFT);

    logic signed [ACC_W-1:0] acc_q, acc_d;
    logic signed [ACC_W:0]   tgt, dlt, stp;
    logic [SH_W-1:0]         sh;
    logic                    pend_q;
    upd_kind_t               kind;

    always_comb begin
        if (ksel > KSEL_W'(MAX_SHIFT))
            sh = SH_W'(MAX_SHIFT);
        else
            sh = SH_W'(ksel);
    end

    always_comb begin
        if (!smp_vld)
            kind = UPD_HOLD;
        else if (pend_q || clr || sh == '0)
            kind = UPD_LOAD;
        else
            kind = UPD_BLEND;
    end

    always_comb begin
        tgt = $signed({smp[SAMPLE_W-1], smp, {FRAC_W{1'b0}}});
        dlt = tgt - $signed({acc_q[ACC_W-1], acc_q});
        stp = dlt >>> sh;
        case (kind)
            UPD_LOAD:  acc_d = tgt[ACC_W-1:0];
            UPD_BLEND: acc_d = acc_q + stp[ACC_W-1:0];
            default:   acc_d = acc_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            pend_q <= 1'b1;
            upd_q  <= 1'b0;
        end else begin
            acc_q <= acc_d;
            upd_q <= smp_vld;
            if (smp_vld)
                pend_q <= 1'b0;
            else if (clr)
                pend_q <= 1'b1;
        end
    end

    assign avg = acc_q[ACC_W-1:FRAC_W];

    AST_DIRECT_LOAD: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && (pend_q || clr || ksel == '0)) |=> (avg == $past(smp))) // R4
        else $error("direct load mismatch");

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |=> $stable(acc_q)) // R6
        else $error("average moved without a sample");

    AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && !dlt[ACC_W]) |=>
            (acc_q >= $past(acc_q)) && ($signed({acc_q[ACC_W-1], acc_q}) <= $past(tgt))) // R3
        else $error("upward step out of bounds");

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && dlt[ACC_W]) |=>
            (acc_q <= $past(acc_q)) && ($signed({acc_q[ACC_W-1], acc_q}) >= $past(tgt))) // R3
        else $error("downward step out of bounds");

endmodule

// File: rtl/exp_avg_diff.sv
module exp_avg_diff
    import exp_avg_pkg::*;
#(
    parameter int SAMPLE_W = DEF_SAMPLE_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       sig_upd,
    input  logic signed [SAMPLE_W-1:0] sig_avg,
    input  logic signed [SAMPLE_W-1:0] zero_avg,
    output logic signed [SAMPLE_W-1:0] res_diff,
    output logic                       res_vld
);
    localparam logic signed [SAMPLE_W-1:0] POS_LIM = {1'b0, {(SAMPLE_W-1){1'b1}}};
    localparam logic signed [SAMPLE_W-1:0] NEG_LIM = {1'b1, {(SAMPLE_W-1){1'b0}}};

    logic signed [SAMPLE_W:0]   raw;
    logic signed [SAMPLE_W-1:0] sat;

    always_comb begin
        raw = $signed({sig_avg[SAMPLE_W-1], sig_avg}) - $signed({zero_avg[SAMPLE_W-1], zero_avg});
        if (raw[SAMPLE_W] != raw[SAMPLE_W-1])
            sat = raw[SAMPLE_W] ? NEG_LIM : POS_LIM;
        else
            sat = raw[SAMPLE_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_diff <= '0;
            res_vld  <= 1'b0;
        end else begin
            res_vld <= sig_upd;
            if (sig_upd)
                res_diff <= sat;
        end
    end

    AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        sig_upd |=> res_vld) // R7
        else $error("missing result strobe");

    AST_STROBE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !sig_upd |=> !res_vld) // R7
        else $error("spurious result strobe");

    AST_DIFF_SIGN: assert property (@(posedge clk) disable iff (rst)
        res_vld |-> (res_diff[SAMPLE_W-1] == ($past(sig_avg) < $past(zero_avg)))) // R8
        else $error("difference sign wrong");

endmodule

// File: rtl/exp_avg_top.sv
module exp_avg_top
    import exp_avg_pkg::*;
#(
    parameter int SAMPLE_W  = DEF_SAMPLE_W,
    parameter int FRAC_W    = DEF_FRAC_W,
    parameter int KSEL_W    = DEF_KSEL_W,
    parameter int MAX_SHIFT = DEF_MAX_SHIFT
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clr,
    input  logic [KSEL_W-1:0]          ksel,
    input  logic                       sig_vld,
    input  logic signed [SAMPLE_W-1:0] sig_smp,
    input  logic                       zero_vld,
    input  logic signed [SAMPLE_W-1:0] zero_smp,
    output logic signed [SAMPLE_W-1:0] sig_avg,
    output logic signed [SAMPLE_W-1:0] zero_avg,
    output logic signed [SAMPLE_W-1:0] res_diff,
    output logic                       res_vld
);
    logic                       ch_vld [N_CH];
    logic signed [SAMPLE_W-1:0] ch_smp [N_CH];
    logic signed [SAMPLE_W-1:0] ch_avg [N_CH];
    logic                       ch_upd [N_CH];

    assign ch_vld[CH_SIG]  = sig_vld;
    assign ch_smp[CH_SIG]  = sig_smp;
    assign ch_vld[CH_ZERO] = zero_vld;
    assign ch_smp[CH_ZERO] = zero_smp;

    for (genvar g = 0; g < N_CH; g++) begin : g_chan
        exp_avg_chan #(
            .SAMPLE_W (SAMPLE_W),
            .FRAC_W   (FRAC_W),
            .KSEL_W   (KSEL_W),
            .MAX_SHIFT(MAX_SHIFT)
        ) u_chan (
            .clk    (clk),
            .rst    (rst),
            .clr    (clr),
            .ksel   (ksel),
            .smp_vld(ch_vld[g]),
            .smp    (ch_smp[g]),
            .avg    (ch_avg[g]),
            .upd_q  (ch_upd[g])
        );
    end

    assign sig_avg  = ch_avg[CH_SIG];
    assign zero_avg = ch_avg[CH_ZERO];

    exp_avg_diff #(
        .SAMPLE_W(SAMPLE_W)
    ) u_diff (
        .clk     (clk),
        .rst     (rst),
        .sig_upd (ch_upd[CH_SIG]),
        .sig_avg (ch_avg[CH_SIG]),
        .zero_avg(ch_avg[CH_ZERO]),
        .res_diff(res_diff),
        .res_vld (res_vld)
    );

    AST_ZERO_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        (!sig_vld && zero_vld) |=> ##1 !res_vld) // R6
        else $error("baseline sample produced a result");

endmodule

// File: tb/exp_avg_top_bench.sv
`timescale 1ns/1ps
module exp_avg_top_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clr = 1'b0;
    logic [3:0] ksel = 4'd0;
    logic sig_vld = 1'b0;
    logic zero_vld = 1'b0;
    logic signed [15:0] sig_smp = '0;
    logic signed [15:0] zero_smp = '0;
    logic signed [15:0] sig_avg, zero_avg, res_diff;
    logic res_vld;

    always #2 clk = ~clk;

    exp_avg_top u_exp_avg_top (
        .clk(clk), .rst(rst), .clr(clr), .ksel(ksel),
        .sig_vld(sig_vld), .sig_smp(sig_smp),
        .zero_vld(zero_vld), .zero_smp(zero_smp),
        .sig_avg(sig_avg), .zero_avg(zero_avg),
        .res_diff(res_diff), .res_vld(res_vld)
    );

    typedef struct {
        int diff;
        int savg;
        int zavg;
        string tag;
    } exp_t;

    exp_t   sb_q[$];
    int     n_cmp = 0;
    int     n_bad = 0;
    bit     done  = 1'b0;
    longint m_acc_s, m_acc_z;
    bit     m_pend_s, m_pend_z;

    function automatic int m_avg(input longint a);
        return int'(a >>> 8);
    endfunction

    function automatic int sat16(input int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic longint m_step(input longint acc, input bit load, input int s, input int k);
        longint t;
        int kk;
        t  = longint'(s) * 256;
        kk = (k > 8) ? 8 : k;
        if (load || kk == 0) return t;
        return acc + ((t - acc) >>> kk);
    endfunction

    task automatic check(input string tag, input int act, input int expv);
        n_cmp++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // driver: presents one cycle of stimulus, updates the model, queues the expected result
    task automatic send(input bit sv, input int ss, input bit zv, input int zs,
                        input int k, input bit c, input string tag);
        exp_t e;
        ksel     = 4'(k);
        clr      = c;
        sig_vld  = sv;
        sig_smp  = 16'(ss);
        zero_vld = zv;
        zero_smp = 16'(zs);
        if (sv) begin
            m_acc_s  = m_step(m_acc_s, m_pend_s || c, ss, k);
            m_pend_s = 1'b0;
        end else if (c) m_pend_s = 1'b1;
        if (zv) begin
            m_acc_z  = m_step(m_acc_z, m_pend_z || c, zs, k);
            m_pend_z = 1'b0;
        end else if (c) m_pend_z = 1'b1;
        if (sv) begin
            e.savg = m_avg(m_acc_s);
            e.zavg = m_avg(m_acc_z);
            e.diff = sat16(e.savg - e.zavg);
            e.tag  = tag;
            sb_q.push_back(e);
        end
        @(negedge clk);
        sig_vld  = 1'b0;
        zero_vld = 1'b0;
        clr      = 1'b0;
        if (sv) check({tag, " R7 strobe early"}, int'(res_vld), 0);
        @(negedge clk);
    endtask

    // monitor: compares each produced result against the queue head
    always @(negedge clk) begin
        if (!rst && res_vld) begin
            if (sb_q.size() == 0) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R6/R7 unexpected strobe: actual 1 expected 0");
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check({e.tag, " diff"}, int'(res_diff), e.diff);
                check({e.tag, " sig_avg"}, int'(sig_avg), e.savg);
                check({e.tag, " zero_avg"}, int'(zero_avg), e.zavg);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int sv_s, sv_z;
        m_acc_s = 0; m_acc_z = 0; m_pend_s = 1'b1; m_pend_z = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 sig_avg", int'(sig_avg), 0);
        check("R1 zero_avg", int'(zero_avg), 0);
        check("R1 res_diff", int'(res_diff), 0);
        check("R1 res_vld", int'(res_vld), 0);

        // R2 first sample loads directly even at k=3
        send(1, 1000, 0, 0, 3, 0, "R2 first sig");
        check("R2 sig loaded", int'(sig_avg), 1000);
        send(0, 0, 1, -200, 3, 0, "R2 first zero");
        check("R2 zero loaded", int'(zero_avg), -200);
        check("R6 sig untouched", int'(sig_avg), 1000);

        // R3 constant sequence at k=3
        for (int i = 0; i < 6; i++) send(1, 3000, 0, 0, 3, 0, "R3 k3 ramp");
        // R3 alternating signs at k=1
        for (int i = 0; i < 6; i++) send(1, (i % 2) ? -777 : 555, 0, 0, 1, 0, "R3 k1 alt");
        // R12 both channels in same cycle
        send(1, 400, 1, 900, 2, 0, "R12 joint");

        // R6 baseline-only sample: no strobe, signal average held
        sv_s = int'(sig_avg);
        send(0, 0, 1, 123, 2, 0, "R6 zero only");
        @(negedge clk);
        check("R6 sig held", int'(sig_avg), sv_s);
        check("R6 no strobe", int'(res_vld), 0);

        // R4 setting zero replaces
        send(1, -4321, 0, 0, 0, 0, "R4 replace");
        check("R4 sig direct", int'(sig_avg), -4321);

        // R5 setting 12 behaves as 8
        send(1, 0, 1, 0, 0, 0, "R5 preload");
        send(1, 25600, 0, 0, 12, 0, "R5 k12");
        check("R5 k12 as k8", int'(sig_avg), 100);

        // R11 fraction kept at k=8
        send(1, 0, 1, 0, 0, 0, "R11 preload");
        for (int i = 0; i < 40; i++) send(1, 64, 0, 0, 8, 0, "R11 small");
        check("R11 moved", int'(sig_avg != 0), 1);

        // R10 setting change keeps stored values
        sv_s = int'(sig_avg);
        sv_z = int'(zero_avg);
        ksel = 4'd2;
        repeat (3) @(negedge clk);
        check("R10 sig kept", int'(sig_avg), sv_s);
        check("R10 zero kept", int'(zero_avg), sv_z);
        send(1, 2000, 0, 0, 2, 0, "R10 new k");

        // R9 clear alone changes nothing, then direct loads
        sv_s = int'(sig_avg);
        sv_z = int'(zero_avg);
        send(0, 0, 0, 0, 5, 1, "R9 clear");
        check("R9 sig after clr", int'(sig_avg), sv_s);
        check("R9 zero after clr", int'(zero_avg), sv_z);
        send(1, 7777, 0, 0, 5, 0, "R9 sig reload");
        check("R9 sig direct", int'(sig_avg), 7777);
        send(0, 0, 1, -50, 5, 0, "R9 zero reload");
        check("R9 zero direct", int'(zero_avg), -50);
        send(1, 6000, 0, 0, 5, 0, "R9 blend again");
        // R9 clear together with a sample
        send(1, -1234, 0, 0, 5, 1, "R9 clr with sample");
        check("R9 same-cycle load", int'(sig_avg), -1234);

        // R8 saturation both ways
        send(1, 32767, 1, -32768, 0, 0, "R8 pos sat");
        send(1, -32768, 1, 32767, 0, 0, "R8 neg sat");
        send(1, 100, 1, 300, 0, 0, "R8 plain neg");

        repeat (4) @(negedge clk);
        check("R7 all results seen", sb_q.size(), 0);
        finish_run();
    end

endmodule